// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 32-bit virtual address to a 36-bit physical address after a translation miss. A walk begins in a context table, whose base comes from a pointer register and whose entry is chosen by the current context number. The walk then descends through at most three levels of page tables in physical memory. Each fetched 32-bit entry is either a pointer to the next table, a leaf page entry, or invalid. The walk ends at the first leaf found at level 1, 2 or 3, and those leaves map 16 MB, 256 KB and 4 KB pages.

The walker accepts one request at a time and keeps a single read outstanding on its memory port. A request may translate, probe or flush. When it finishes, the walker raises a one-cycle done pulse. With that pulse it presents the leaf entry, the level where the leaf was found and the physical address. On a failed translation it presents a fault type and the level code where the walk stopped, and a fault register block alongside captures these. When translation is disabled, addresses pass straight through without any memory traffic.

Top module: `ptw_walker`

## Requirements
- R1: A translate request (op 00) with `en_i` low completes with `paddr_o` = {4'b0, vaddr}, `level_o` = 0, no fault and no memory read.
- R2: The first read of a walk goes to {ctp_i[31:2], 6'b0} + 4 × context number.
- R3: Entry type sits in bits 1:0: 0 invalid, 1 table pointer, 2 page entry, 3 reserved. A pointer's next table base is {entry[31:2], 6'b0}. Level 1, 2 and 3 entries sit at base + 4 × vaddr[31:24], [23:18] and [17:12] respectively.
- R4: A page entry at level L (1..3) ends the walk with `level_o` = L and `pte_o` = entry. `paddr_o` is {entry[31:20], va[23:0]} at L1, {entry[31:14], va[17:0]} at L2 and {entry[31:8], va[11:0]} at L3.
- R5: An invalid entry ends the walk with fault type 1, and `fault_level_o` is the level code of the table it came from (0 = context table, 1..3 = page tables).
- R6: A reserved-type entry, a pointer read at level 3, or a page entry read from the context table raises fault type 4 at that level.
- R7: An error response on the read port raises fault type 5 at the current level.
- R8: On a fault, `fault_at_o` repeats the request's access type, and both `paddr_o` and `pte_o` are zero.
- R9: A probe (op 01) walks regardless of `en_i` and never faults. It returns the leaf entry when one is found, and zero entry and level otherwise.
- R10: A flush (op 1x) completes with `tlb_flush_o` high for the single done cycle and performs no memory read.
- R11: `mem_req_o` is never high on two consecutive cycles, `done_o` is a single-cycle pulse, and a request presented while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Translation enable |
| ctp_i | input | 32 | Context table pointer register (bits 31:2 = physical bits 35:6) |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 00 translate, 01 probe, 1x flush |
| req_vaddr_i | input | 32 | Virtual address |
| req_ctx_i | input | CTX_W | Context number |
| req_at_i | input | 3 | Access type, reported with faults |
| busy_o | output | 1 | Walk or response in progress |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 36 | Physical address of the entry to read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_err_i | input | 1 | Read response carries a bus error |
| mem_rdata_i | input | 32 | Entry read from memory |
| done_o | output | 1 | Result valid, one cycle |
| tlb_flush_o | output | 1 | Invalidate all cached translations |
| paddr_o | output | 36 | Translated physical address |
| pte_o | output | 32 | Leaf entry found |
| level_o | output | 2 | Level of the leaf |
| fault_o | output | 1 | Walk failed |
| fault_type_o | output | 3 | 1 invalid, 4 translation error, 5 bus error |
| fault_level_o | output | 2 | Level code where the walk failed |
| fault_at_o | output | 3 | Access type of the failed request |

## Verification
A bench memory holds a small tree in which one context leads to leaves at each of the three levels, and each kind of bad entry sits at a known depth. Walks ending at levels 1, 2 and 3 separate the three page-size splices of the address. Invalid, reserved and misplaced entries, together with bus errors at the context table and at level 2, show that the fault code and the level code are derived separately. The number of reads counted per request exposes a walk that stops early or runs too deep, and that count also confirms that pass-through and flush requests touch no memory. Probes of a mapped and an unmapped address, including one made with translation disabled, show that faults are suppressed while the leaf is still returned.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 36;
  localparam int ENT_W     = 32;
  localparam int PAGE_BITS = 12;
  localparam int L3_BITS   = 6;
  localparam int L2_BITS   = 6;
  localparam int L1_BITS   = 8;
  localparam int L2_LSB    = PAGE_BITS + L3_BITS;
  localparam int L1_LSB    = L2_LSB + L2_BITS;
  localparam int TBL_ALIGN = 6;
  localparam int ENT_LOG   = 2;

  typedef enum logic [1:0] {
    ET_INV = 2'd0,
    ET_PTD = 2'd1,
    ET_PTE = 2'd2,
    ET_RSV = 2'd3
  } etype_e;

  typedef enum logic [2:0] {
    FT_NONE  = 3'd0,
    FT_INV   = 3'd1,
    FT_TRANS = 3'd4,
    FT_BUS   = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_RESP
  } state_e;

  localparam logic [1:0] OP_XLATE = 2'b00;
  localparam logic [1:0] OP_PROBE = 2'b01;

  // unmapped offset width of a leaf at a level
  function automatic int off_bits(input int lvl);
    case (lvl)
      1:       return L1_LSB;
      2:       return L2_LSB;
      default: return PAGE_BITS;
    endcase
  endfunction
endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [1:0]       level_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PA_W-1:0] idx;

  always_comb begin
    case (level_i)
      2'd0:    idx = PA_W'(ctx_i);
      2'd1:    idx = PA_W'(vaddr_i[L1_LSB +: L1_BITS]);
      2'd2:    idx = PA_W'(vaddr_i[L2_LSB +: L2_BITS]);
      default: idx = PA_W'(vaddr_i[PAGE_BITS +: L3_BITS]);
    endcase
  end

  assign addr_o = base_i + (idx << ENT_LOG);
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic [1:0]       level_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output etype_e           etype_o,
  output logic [PA_W-1:0]  next_base_o,
  output logic [PA_W-1:0]  leaf_pa_o
);
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [PA_W-1:0] page;
  logic [PA_W-1:0] va_ext;
  logic [PA_W-1:0] pa_lvl [4];

  assign etype_o     = etype_e'(entry_i[1:0]);
  assign next_base_o = {entry_i[ENT_W-1:2], TBL_ALIGN'(0)};
  assign page        = {entry_i[ENT_W-1 -: PPN_W], PAGE_BITS'(0)};
  assign va_ext      = PA_W'(vaddr_i);
  assign pa_lvl[0]   = '0;

  for (genvar g = 1; g < 4; g++) begin : g_lvl
    localparam int OW = off_bits(g);
    assign pa_lvl[g] = {page[PA_W-1:OW], va_ext[OW-1:0]};
  end

  assign leaf_pa_o = pa_lvl[level_i];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [31:0]      ctp_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [31:0]      req_vaddr_i,
  input  logic [CTX_W-1:0] req_ctx_i,
  input  logic [2:0]       req_at_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [35:0]      mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic             mem_err_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             done_o,
  output logic             tlb_flush_o,
  output logic [35:0]      paddr_o,
  output logic [31:0]      pte_o,
  output logic [1:0]       level_o,
  output logic             fault_o,
  output logic [2:0]       fault_type_o,
  output logic [1:0]       fault_level_o,
  output logic [2:0]       fault_at_o
);
  state_e           state_q;
  logic [1:0]       lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  logic [2:0]       at_q;
  logic [1:0]       op_q;
  logic [PA_W-1:0] res_pa_q;
  logic [ENT_W-1:0] res_pte_q;
  logic [1:0]       res_lvl_q;
  logic             res_flt_q;
  fault_e           res_ft_q;
  logic [1:0]       res_fl_q;

  etype_e          etype;
  logic [PA_W-1:0] next_base;
  logic [PA_W-1:0] leaf_pa;
  logic            is_probe;

  ptw_index_gen #(.CTX_W(CTX_W)) u_index (
    .level_i (lvl_q),
    .base_i  (base_q),
    .vaddr_i (va_q),
    .ctx_i   (ctx_q),
    .addr_o  (mem_addr_o)
  );

  ptw_entry_decode u_decode (
    .entry_i     (mem_rdata_i),
    .level_i     (lvl_q),
    .vaddr_i     (va_q),
    .etype_o     (etype),
    .next_base_o (next_base),
    .leaf_pa_o   (leaf_pa)
  );

  assign is_probe = (op_q == OP_PROBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      lvl_q     <= '0;
      base_q    <= '0;
      va_q      <= '0;
      ctx_q     <= '0;
      at_q      <= '0;
      op_q      <= OP_XLATE;
      res_pa_q  <= '0;
      res_pte_q <= '0;
      res_lvl_q <= '0;
      res_flt_q <= 1'b0;
      res_ft_q  <= FT_NONE;
      res_fl_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            va_q      <= req_vaddr_i;
            ctx_q     <= req_ctx_i;
            at_q      <= req_at_i;
            op_q      <= req_op_i;
            lvl_q     <= '0;
            base_q    <= {ctp_i[31:2], TBL_ALIGN'(0)};
            res_pa_q  <= '0;
            res_pte_q <= '0;
            res_lvl_q <= '0;
            res_flt_q <= 1'b0;
            res_ft_q  <= FT_NONE;
            res_fl_q  <= '0;
            if (req_op_i[1]) begin
              state_q <= S_RESP;
            end else if (req_op_i == OP_XLATE && !en_i) begin
              res_pa_q <= PA_W'(req_vaddr_i);
              state_q  <= S_RESP;
            end else begin
              state_q <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (mem_rvalid_i) begin
            state_q <= S_RESP;
            if (mem_err_i) begin
              res_flt_q <= !is_probe;
              res_ft_q  <= is_probe ? FT_NONE : FT_BUS;
              res_fl_q  <= is_probe ? 2'd0 : lvl_q;
            end else begin
              case (etype)
                ET_PTD: begin
                  if (lvl_q == 2'd3) begin
                    res_flt_q <= !is_probe;
                    res_ft_q  <= is_probe ? FT_NONE : FT_TRANS;
                    res_fl_q  <= is_probe ? 2'd0 : lvl_q;
                  end else begin
                    base_q  <= next_base;
                    lvl_q   <= lvl_q + 2'd1;
                    state_q <= S_ISSUE;
                  end
                end
                ET_PTE: begin
                  if (lvl_q == 2'd0) begin
                    res_flt_q <= !is_probe;
                    res_ft_q  <= is_probe ? FT_NONE : FT_TRANS;
                    res_fl_q  <= '0;
                  end else begin
                    res_pte_q <= mem_rdata_i;
                    res_pa_q  <= leaf_pa;
                    res_lvl_q <= lvl_q;
                  end
                end
                ET_INV: begin
                  res_flt_q <= !is_probe;
                  res_ft_q  <= is_probe ? FT_NONE : FT_INV;
                  res_fl_q  <= is_probe ? 2'd0 : lvl_q;
                end
                default: begin
                  res_flt_q <= !is_probe;
                  res_ft_q  <= is_probe ? FT_NONE : FT_TRANS;
                  res_fl_q  <= is_probe ? 2'd0 : lvl_q;
                end
              endcase
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != S_IDLE);
  assign mem_req_o     = (state_q == S_ISSUE);
  assign done_o        = (state_q == S_RESP);
  assign tlb_flush_o   = done_o && op_q[1];
  assign paddr_o       = res_pa_q;
  assign pte_o         = res_pte_q;
  assign level_o       = res_lvl_q;
  assign fault_o       = done_o && res_flt_q;
  assign fault_type_o  = res_ft_q;
  assign fault_level_o = res_fl_q;
  assign fault_at_o    = res_flt_q ? at_q : 3'd0;

  a_r11_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r1_no_read_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !en_i && req_op_i == OP_XLATE) |=> (done_o && !mem_req_o));

  a_r10_flush_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_op_i[1]) |=> (tlb_flush_o && !mem_req_o));

  a_r9_probe_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_probe) |-> !fault_o);

  a_r5_fault_coded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_type_o != 3'd0 && pte_o == '0));

  a_r4_leaf_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pte_o[1:0] == 2'b10) |-> (level_o != 2'd0 && !fault_o));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  localparam int CLK_PERIOD = 10;
  localparam int CTX_W      = 8;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic [1:0]  op;
    logic        en;
    logic [2:0]  at;
    logic [3:0]  ctx;
    logic [31:0] va;
    logic        flt;
    logic [2:0]  ft;
    logic [1:0]  fl;
    logic [1:0]  lvl;
    logic [31:0] pte;
    logic [3:0]  nrd;
  } vec_t;

  // op en at ctx va flt ft fl lvl pte reads
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 3'd0, 4'd1, 32'h3418_1ABC, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0ABC_DE62, 4'd4},
    '{2'd0, 1'b1, 3'd1, 4'd1, 32'h3416_3456, 1'b0, 3'd0, 2'd0, 2'd2, 32'h1234_5602, 4'd3},
    '{2'd0, 1'b1, 3'd2, 4'd1, 32'h1276_5432, 1'b0, 3'd0, 2'd0, 2'd1, 32'hABC0_0002, 4'd2},
    '{2'd0, 1'b1, 3'd4, 4'd1, 32'h5600_0000, 1'b1, 3'd1, 2'd1, 2'd0, 32'h0,         4'd2},
    '{2'd0, 1'b1, 3'd5, 4'd1, 32'h341C_0000, 1'b1, 3'd1, 2'd2, 2'd0, 32'h0,         4'd3},
    '{2'd0, 1'b1, 3'd3, 4'd1, 32'h3418_3000, 1'b1, 3'd1, 2'd3, 2'd0, 32'h0,         4'd4},
    '{2'd0, 1'b1, 3'd6, 4'd1, 32'h3420_0000, 1'b1, 3'd4, 2'd2, 2'd0, 32'h0,         4'd3},
    '{2'd0, 1'b1, 3'd7, 4'd1, 32'h3418_2000, 1'b1, 3'd4, 2'd3, 2'd0, 32'h0,         4'd4},
    '{2'd0, 1'b1, 3'd0, 4'd3, 32'h0000_0000, 1'b1, 3'd4, 2'd0, 2'd0, 32'h0,         4'd1},
    '{2'd0, 1'b1, 3'd1, 4'd2, 32'h0000_0000, 1'b1, 3'd1, 2'd0, 2'd0, 32'h0,         4'd1},
    '{2'd0, 1'b1, 3'd2, 4'd1, 32'h3424_0000, 1'b1, 3'd5, 2'd2, 2'd0, 32'h0,         4'd3},
    '{2'd0, 1'b1, 3'd4, 4'd4, 32'h0000_0000, 1'b1, 3'd5, 2'd0, 2'd0, 32'h0,         4'd1},
    '{2'd0, 1'b0, 3'd0, 4'd1, 32'hDEAD_BEEF, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0,         4'd0},
    '{2'd1, 1'b1, 3'd0, 4'd1, 32'h3418_1ABC, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0ABC_DE62, 4'd4},
    '{2'd1, 1'b1, 3'd0, 4'd1, 32'h5600_0000, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0,         4'd2},
    '{2'd1, 1'b0, 3'd0, 4'd1, 32'h1276_5432, 1'b0, 3'd0, 2'd0, 2'd1, 32'hABC0_0002, 4'd2}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [31:0]      ctp_i = 32'h0000_1000;
  logic             req_valid_i = 1'b0;
  logic [1:0]       req_op_i = 2'd0;
  logic [31:0]      req_vaddr_i = '0;
  logic [CTX_W-1:0] req_ctx_i = '0;
  logic [2:0]       req_at_i = '0;
  logic             busy_o, mem_req_o, done_o, tlb_flush_o, fault_o;
  logic [35:0]      mem_addr_o, paddr_o;
  logic             mem_rvalid_i = 1'b0;
  logic             mem_err_i = 1'b0;
  logic [31:0]      mem_rdata_i = '0;
  logic [31:0]      pte_o;
  logic [1:0]       level_o, fault_level_o;
  logic [2:0]       fault_type_o, fault_at_o;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  logic [31:0] mem_q [logic [35:0]];
  bit          err_q [logic [35:0]];

  ptw_walker #(.CTX_W(CTX_W)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] leaf_pa(input logic [31:0] pte, input logic [1:0] lvl, input logic [31:0] va);
    case (lvl)
      2'd1:    return {pte[31:20], va[23:0]};
      2'd2:    return {pte[31:14], va[17:0]};
      default: return {pte[31:8],  va[11:0]};
    endcase
  endfunction

  // memory responder: fixed latency of two cycles after each read
  initial begin
    int lat = 0;
    logic [35:0] a = '0;
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      mem_err_i    = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rvalid_i = 1'b1;
          mem_err_i    = err_q.exists(a);
          mem_rdata_i  = mem_q.exists(a) ? mem_q[a] : 32'h0;
        end
      end
      if (mem_req_o) begin
        a = mem_addr_o;
        lat = 2;
        rd_cnt++;
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic en, input logic [2:0] at,
                       input logic [3:0] ctx, input logic [31:0] va);
    @(negedge clk_i);
    rd_cnt      = 0;
    en_i        = en;
    req_op_i    = op;
    req_at_i    = at;
    req_ctx_i   = CTX_W'(ctx);
    req_vaddr_i = va;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  initial begin
    mem_q[36'h10004] = 32'h0000_2001;
    mem_q[36'h1000C] = 32'h0000_0002;
    err_q[36'h10010] = 1'b1;
    mem_q[36'h20048] = 32'hABC0_0002;
    mem_q[36'h200D0] = 32'h0000_3001;
    mem_q[36'h30014] = 32'h1234_5602;
    mem_q[36'h30018] = 32'h0000_4001;
    mem_q[36'h30020] = 32'h0000_0003;
    err_q[36'h30024] = 1'b1;
    mem_q[36'h40004] = 32'h0ABC_DE62;
    mem_q[36'h40008] = 32'h0000_0001;

    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !mem_req_o && !tlb_flush_o && !fault_o, "R11 reset state",
          {busy_o, done_o, mem_req_o, tlb_flush_o, fault_o}, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      bit ok;
      logic [35:0] exp_pa;
      issue(VEC[v].op, VEC[v].en, VEC[v].at, VEC[v].ctx, VEC[v].va);
      wait_done(ok);
      check(ok, "R11 walk completes", ok, 1);
      if (VEC[v].flt)                          exp_pa = '0;
      else if (VEC[v].op == 2'd0 && !VEC[v].en) exp_pa = {4'h0, VEC[v].va};
      else if (VEC[v].lvl == 2'd0)             exp_pa = '0;
      else                                     exp_pa = leaf_pa(VEC[v].pte, VEC[v].lvl, VEC[v].va);
      // R2 R3: wrong table addressing lands on unmapped words or changes the read count
      check(rd_cnt == int'(VEC[v].nrd), $sformatf("R2 R3 R1 reads v%0d", v), rd_cnt, VEC[v].nrd);
      check(fault_o == VEC[v].flt, $sformatf("R5 R6 R7 R9 fault v%0d", v), fault_o, VEC[v].flt);
      if (VEC[v].flt) begin
        check(fault_type_o == VEC[v].ft, $sformatf("R5 R6 R7 type v%0d", v), fault_type_o, VEC[v].ft);
        check(fault_level_o == VEC[v].fl, $sformatf("R5 R6 R7 level v%0d", v), fault_level_o, VEC[v].fl);
        check(fault_at_o == VEC[v].at, $sformatf("R8 access type v%0d", v), fault_at_o, VEC[v].at);
      end
      check(paddr_o == exp_pa, $sformatf("R4 R1 R8 paddr v%0d", v), paddr_o, exp_pa);
      check(pte_o == VEC[v].pte, $sformatf("R4 R9 pte v%0d", v), pte_o, VEC[v].pte);
      check(level_o == VEC[v].lvl, $sformatf("R4 level v%0d", v), level_o, VEC[v].lvl);
      check(!tlb_flush_o, "R10 no flush on walk", tlb_flush_o, 0);
      @(negedge clk_i);
      check(!done_o, "R11 done single cycle", done_o, 0);
    end

    // R10: flush request
    begin
      bit ok;
      issue(2'b10, 1'b1, 3'd0, 4'd1, 32'h0000_0400);
      wait_done(ok);
      check(ok && tlb_flush_o, "R10 flush pulse", tlb_flush_o, 1);
      check(rd_cnt == 0, "R10 flush no read", rd_cnt, 0);
      @(negedge clk_i);
      check(!tlb_flush_o, "R10 flush one cycle", tlb_flush_o, 0);
    end

    // R11: request held while busy must be ignored
    begin
      bit ok;
      @(negedge clk_i);
      rd_cnt      = 0;
      en_i        = 1'b1;
      req_op_i    = 2'd0;
      req_ctx_i   = CTX_W'(1);
      req_vaddr_i = 32'h3418_1ABC;
      req_valid_i = 1'b1;
      @(negedge clk_i);
      req_vaddr_i = 32'h1276_5432;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      wait_done(ok);
      check(ok && level_o == 2'd3, "R11 busy request ignored level", level_o, 3);
      check(pte_o == 32'h0ABC_DE62, "R11 busy request ignored pte", pte_o, 32'h0ABC_DE62);
      @(negedge clk_i);
      @(negedge clk_i);
      check(!busy_o && !done_o, "R11 no second walk", {busy_o, done_o}, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule